// File: doc/BRIEF.md
# Single-Bit Modify and Test-Skip Unit

This unit sits in the execute stage of a small 8-bit core. It looks at the 13-bit instruction word. When that word is one of the four single-bit operations, the unit either forces one chosen bit of the register operand to 0 or 1 and asks for the byte to be written back, or it examines one chosen bit and asks the sequencer to skip the next instruction. The register file, the fetch logic and the squashing of the skipped instruction live outside this unit. None of the four operations touches the status flags, so the unit has no flag outputs.

The instruction fields are laid out as follows, from the most significant bit down:

| Bits | Content |
|------|---------|
| 12 | always 0 |
| 11 | always 1 |
| 10:9 | two-bit operation code |
| 8:6 | bit index |
| 5:0 | register address |

Every output is combinational from the instruction word and the operand. An input strobe, `valid_i`, qualifies the write enable and the skip request. The sequencer turns a skip request into a second instruction cycle. A test whose skip is not taken therefore costs one cycle, and a test whose skip is taken costs two.

Top module: `bitop_unit`

## Requirements
- R1: A word is a bit operation only when bit 12 is 0 and bit 11 is 1. For any other word, `hit_o`, `wr_en_o` and `skip_o` are 0 and `result_o` equals the operand.
- R2: Operation code 00 (clear) drives bit `instr[8:6]` of `result_o` to 0. It raises `wr_en_o` while `valid_i` is 1.
- R3: Operation code 01 (set) drives bit `instr[8:6]` of `result_o` to 1. It raises `wr_en_o` while `valid_i` is 1.
- R4: For clear and set, every bit of `result_o` other than the selected one equals the operand, so at most one bit differs.
- R5: Operation code 10 (test-skip-if-zero) raises `skip_o` exactly when the selected operand bit is 0 and `valid_i` is 1.
- R6: Operation code 11 (test-skip-if-one) raises `skip_o` exactly when the selected operand bit is 1 and `valid_i` is 1.
- R7: The two test operations never raise `wr_en_o`, and for them `result_o` equals the operand.
- R8: While `valid_i` is 0, `wr_en_o` and `skip_o` stay 0 whatever the instruction and operand.
- R9: `addr_o` always equals `instr[5:0]`, and `hit_o` is 1 for every bit operation.
- R10: `wr_en_o` and `skip_o` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr_i | input | 13 | Instruction word |
| valid_i | input | 1 | Qualifies write enable and skip request |
| opnd_i | input | 8 | Register operand read at `addr_o` |
| hit_o | output | 1 | Word is one of the four bit operations |
| addr_o | output | 6 | Register address field |
| result_o | output | 8 | Byte to write back |
| wr_en_o | output | 1 | Write-back request (clear/set) |
| skip_o | output | 1 | Skip-next-instruction request (tests) |

## Verification
Immediate assertions check on every input change that:
- the write and skip requests are mutually exclusive;
- both requests are quiet while the strobe is low;
- a test operation or a non-bit word passes the operand through;
- a clear or set changes no more than one bit, through a one-hot select.

Only the bench scenarios can show the rest:
- that the selected bit is the one the index field names;
- that it takes the right value;
- that each test skips on its own polarity;
- that the address field reaches `addr_o`.

The bench shows these by sweeping every index against several operand patterns.

// File: rtl/bitop_pkg.sv
// Package: shared operation encoding for the single-bit unit.
// Assumes the two-bit operation code sits just above the bit index field.
package bitop_pkg;

    typedef enum logic [1:0] {
        BOP_CLR     = 2'b00,
        BOP_SET     = 2'b01,
        BOP_SKIP_LO = 2'b10,
        BOP_SKIP_HI = 2'b11
    } bitop_e;

endpackage

// File: rtl/bitop_decode.sv
// Module: bitop_decode
// Splits a 13-bit word into class hit, operation code, bit index and address.
// Assumes INSTR_W equals ADDR_W + IDX_W + 4 (two class bits, two opcode bits).
module bitop_decode
    import bitop_pkg::*;
#(
    parameter int INSTR_W = 13,
    parameter int IDX_W   = 3,
    parameter int ADDR_W  = 6
) (
    input  logic [INSTR_W-1:0] instr,
    output logic               hit,
    output bitop_e             op,
    output logic [IDX_W-1:0]   idx,
    output logic [ADDR_W-1:0]  addr
);
    localparam int IDX_LSB = ADDR_W;
    localparam int OP_LSB  = ADDR_W + IDX_W;

    // Purpose: field extraction and class recognition.
    always_comb begin
        hit  = (instr[INSTR_W-1] == 1'b0) && (instr[INSTR_W-2] == 1'b1);
        op   = bitop_e'(instr[OP_LSB +: 2]);
        idx  = instr[IDX_LSB +: IDX_W];
        addr = instr[ADDR_W-1:0];
    end
endmodule

// File: rtl/bitop_modify.sv
// Module: bitop_modify
// Forces one selected bit of the operand to set_val; the other bits pass through.
// Assumes DATA_W <= 2**IDX_W so each index names at most one lane.
module bitop_modify #(
    parameter int DATA_W = 8,
    parameter int IDX_W  = 3
) (
    input  logic [DATA_W-1:0] opnd,
    input  logic [IDX_W-1:0]  idx,
    input  logic              set_val,
    output logic [DATA_W-1:0] result
);
    logic [DATA_W-1:0] sel;

    for (genvar i = 0; i < DATA_W; i++) begin : g_lane
        // Purpose: one lane compares the index against its own position.
        always_comb begin
            sel[i]    = (idx == IDX_W'(i));
            result[i] = sel[i] ? set_val : opnd[i];
        end
    end

    // Purpose: R4 guard, one-hot lane select and a single changed bit at most.
    always_comb begin
        a_r4_sel_onehot: assert ($onehot(sel))
            else $error("lane select not one-hot");
        a_r4_single_change: assert ($countones(result ^ opnd) <= 1)
            else $error("more than one bit modified");
    end
endmodule

// File: rtl/bitop_test.sv
// Module: bitop_test
// Picks one operand bit and reports whether it matches the skip polarity.
// Assumes the index is in range of DATA_W.
module bitop_test #(
    parameter int DATA_W = 8,
    parameter int IDX_W  = 3
) (
    input  logic [DATA_W-1:0] opnd,
    input  logic [IDX_W-1:0]  idx,
    input  logic              skip_on_one,
    output logic              skip_req
);
    logic picked;

    // Purpose: bit pick and polarity compare.
    always_comb begin
        picked   = opnd[idx];
        skip_req = (picked == skip_on_one);
    end
endmodule

// File: rtl/bitop_unit.sv
// Module: bitop_unit (top)
// Executes the clear, set and two test-skip single-bit operations.
// Purely combinational: the write enable and skip request are gated by valid_i.
// Assumes the sequencer owns storage, write-back timing and the skip squash.
module bitop_unit
    import bitop_pkg::*;
#(
    parameter int INSTR_W = 13,
    parameter int DATA_W  = 8,
    parameter int ADDR_W  = 6,
    localparam int IDX_W  = $clog2(DATA_W)
) (
    input  logic [INSTR_W-1:0] instr_i,
    input  logic               valid_i,
    input  logic [DATA_W-1:0]  opnd_i,
    output logic               hit_o,
    output logic [ADDR_W-1:0]  addr_o,
    output logic [DATA_W-1:0]  result_o,
    output logic               wr_en_o,
    output logic               skip_o
);
    bitop_e           op;
    logic [IDX_W-1:0] idx;
    logic [DATA_W-1:0] mod_res;
    logic             skip_req;
    logic             is_mod;
    logic             is_test;

    bitop_decode #(.INSTR_W(INSTR_W), .IDX_W(IDX_W), .ADDR_W(ADDR_W)) dec_i (
        .instr (instr_i),
        .hit   (hit_o),
        .op    (op),
        .idx   (idx),
        .addr  (addr_o)
    );

    bitop_modify #(.DATA_W(DATA_W), .IDX_W(IDX_W)) mod_i (
        .opnd    (opnd_i),
        .idx     (idx),
        .set_val (op[0]),
        .result  (mod_res)
    );

    bitop_test #(.DATA_W(DATA_W), .IDX_W(IDX_W)) tst_i (
        .opnd        (opnd_i),
        .idx         (idx),
        .skip_on_one (op[0]),
        .skip_req    (skip_req)
    );

    // Purpose: route by operation class and gate requests with the strobe.
    always_comb begin
        is_mod   = hit_o && !op[1];
        is_test  = hit_o && op[1];
        result_o = is_mod ? mod_res : opnd_i;
        wr_en_o  = valid_i && is_mod;
        skip_o   = valid_i && is_test && skip_req;
    end

    // Purpose: cross-module guards on the outputs.
    always_comb begin
        a_r10_no_write_and_skip: assert (!(wr_en_o && skip_o))
            else $error("write and skip together");
        a_r8_idle_quiet: assert (valid_i || (!wr_en_o && !skip_o))
            else $error("request without strobe");
        a_r7_test_passthru: assert (!is_test || (result_o == opnd_i && !wr_en_o))
            else $error("test operation altered data");
        a_r1_foreign_quiet: assert (hit_o || (!wr_en_o && !skip_o && result_o == opnd_i))
            else $error("non-bit word had effect");
    end
endmodule

// File: tb/bitop_unit_tb_top.sv
// Directed bench for bitop_unit: one task per scenario, each checks its own results.
module bitop_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [12:0] instr;
    logic        valid;
    logic [7:0]  opnd;
    logic        hit, wr_en, skip;
    logic [5:0]  addr;
    logic [7:0]  result;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    bitop_unit dut_i (
        .instr_i  (instr),
        .valid_i  (valid),
        .opnd_i   (opnd),
        .hit_o    (hit),
        .addr_o   (addr),
        .result_o (result),
        .wr_en_o  (wr_en),
        .skip_o   (skip)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive on the falling edge, sample a quarter period later.
    task automatic apply(input logic [1:0] op, input int b, input logic [5:0] a,
                         input logic [7:0] d, input logic v);
        @(negedge clk);
        instr = {2'b01, op, 3'(b), a};
        opnd  = d;
        valid = v;
        #5;
    endtask

    task automatic t_reset();
        chk(!wr_en && !skip, "R8 reset", {wr_en, skip}, 0);
    endtask

    task automatic t_clear_set();
        logic [7:0] pats [3] = '{8'hFF, 8'h00, 8'hA5};
        foreach (pats[p]) begin
            for (int b = 0; b < 8; b++) begin
                apply(2'b00, b, 6'(b + 5), pats[p], 1'b1);
                chk(result == (pats[p] & ~(8'h1 << b)), "R2/R4 clear", result,
                    pats[p] & ~(8'h1 << b));
                chk(wr_en && !skip && hit, "R2 wr_en", {hit, wr_en, skip}, 3'b110);
                chk(addr == 6'(b + 5), "R9 addr", addr, b + 5);
                apply(2'b01, b, 6'h3F, pats[p], 1'b1);
                chk(result == (pats[p] | (8'h1 << b)), "R3/R4 set", result,
                    pats[p] | (8'h1 << b));
                chk(wr_en && !skip, "R3 wr_en", {wr_en, skip}, 2'b10);
            end
        end
    endtask

    task automatic t_tests();
        logic [7:0] pats [3] = '{8'h5A, 8'h0F, 8'h81};
        foreach (pats[p]) begin
            for (int b = 0; b < 8; b++) begin
                apply(2'b10, b, 6'h11, pats[p], 1'b1);
                chk(skip == !pats[p][b], "R5 skip-if-zero", skip, !pats[p][b]);
                chk(!wr_en && result == pats[p], "R7 test no write", result, pats[p]);
                apply(2'b11, b, 6'h22, pats[p], 1'b1);
                chk(skip == pats[p][b], "R6 skip-if-one", skip, pats[p][b]);
                chk(!wr_en && result == pats[p], "R7 test no write", result, pats[p]);
                chk(!(wr_en && skip), "R10 exclusive", {wr_en, skip}, 0);
            end
        end
    endtask

    task automatic t_foreign();
        logic [12:0] words [4] = '{13'h0000, 13'h07FF, 13'h1000, 13'h1FFF};
        foreach (words[w]) begin
            @(negedge clk);
            instr = words[w];
            opnd  = 8'h3C;
            valid = 1'b1;
            #5;
            chk(!hit && !wr_en && !skip && result == 8'h3C, "R1 non-bit word",
                {hit, wr_en, skip, result}, 8'h3C);
        end
    endtask

    task automatic t_valid_low();
        for (int op = 0; op < 4; op++) begin
            apply(2'(op), 3, 6'h01, 8'h00, 1'b0);
            chk(!wr_en && !skip, "R8 strobe low", {wr_en, skip}, 0);
            apply(2'(op), 3, 6'h01, 8'hFF, 1'b0);
            chk(!wr_en && !skip && hit, "R8/R9 strobe low", {hit, wr_en, skip}, 3'b100);
        end
    endtask

    initial begin
        instr = '0;
        valid = 1'b0;
        opnd  = '0;
        repeat (2) @(posedge clk);
        #5;
        t_reset();
        rst_n = 1'b1;
        t_clear_set();
        t_tests();
        t_foreign();
        t_valid_low();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule